// File: doc/BRIEF.md
# Externally Clocked Serial Transmitter

This block sends data words, least significant bit first, on a single serial output line. In its normal slave mode the bit timing comes from an external clock pin. The block samples that pin with its own system clock, passes it through a two-flop synchronizer and detects its falling edges. Each detected falling edge produces one single-cycle shift event, and each shift event advances the line by one bit, so a receiver can capture data on the rising edges of the same external clock.

A one-word holding buffer sits in front of the shift register. Software can therefore queue the next word while the current frame is still going out. When a frame ends with a word waiting, that word is reloaded after a fixed two-cycle gap, with the line held high during the gap. No completion pulse is produced in that case. When a frame ends with nothing queued, a completion pulse marks the end of transmission.

If the external clock stops in the middle of a frame, clearing the slave-select input switches the shift events to an internal clock divider. The stalled frame and any queued word then drain out, after which external clocking can be selected again.

Top module: `sync_ser_tx`

## Requirements
- R1: In slave mode (`slave_sel`=1), each falling edge of `ext_clk` produces exactly one shift event after two-flop synchronization. `txd` changes only after such an event and stays stable across the rising edges of `ext_clk`.
- R2: A write (`wr_en`=1) fills the holding buffer. When the transmitter is idle, the word moves into the shift register on the next system clock, and every such move raises `buf_empty_p` for one cycle.
- R3: After a load, the first shift event drives bit 0 of the word onto `txd`. Each later shift event drives the next higher bit.
- R4: `len_sel`=0 gives 8-bit frames (bits 0..7) and `len_sel`=1 gives 7-bit frames (bits 0..6). The value is captured when the word is loaded, so changing `len_sel` during a frame does not affect that frame.
- R5: The shift event after the last bit of a frame returns `txd` to 1. If the buffer is empty at that point, `tx_done_p` pulses high for exactly one cycle and the transmitter goes idle.
- R6: If the buffer holds a word when a frame ends, no `tx_done_p` pulse is produced. `txd` stays at 1 for a two-cycle gap, then the word is loaded (with a `buf_empty_p` pulse) and sent on the following shift events.
- R7: During and after reset, `txd` is 1 and both status pulses are 0. While idle, `txd` stays 1.
- R8: A write to a buffer that already holds an unsent word replaces that word. Only the latest word is transmitted.
- R9: With `slave_sel`=0, shift events come from an internal divider, one every `MDIV` system clocks. This lets a frame stalled by a halted `ext_clk` finish and lets the buffer drain. Setting `slave_sel` back to 1 resumes transmission on `ext_clk` edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Holding-buffer write strobe |
| wr_data | input | DW | Word to transmit |
| len_sel | input | 1 | Frame length select: 0 = DW bits, 1 = DW-1 bits |
| slave_sel | input | 1 | 1 = shift on external clock, 0 = shift on internal divider |
| ext_clk | input | 1 | External shift clock, asynchronous to clk |
| txd | output | 1 | Serial data output, idles high |
| buf_empty_p | output | 1 | One-cycle pulse when the buffer word moves to the shift register |
| tx_done_p | output | 1 | One-cycle pulse when a frame ends with no word queued |

## Verification
The hardest situation to reach from the ports is a stalled external clock with a word already queued, followed by recovery through master mode. The bench starts a frame and advances a few external clock cycles. It then holds `ext_clk` high, writes a second word and clears `slave_sel`. It checks that both words drain and that exactly one completion pulse appears, and then it resumes slave operation with a fresh frame. Back-to-back frames with a double write during the first frame exercise the reload gap and the overwrite together. Random frames with random lengths and random queuing cover the rest.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_SHIFT = 3'd2,
    ST_GAP1  = 3'd3,
    ST_GAP2  = 3'd4
  } tx_state_e;
endpackage

// File: rtl/sst_edge.sv
module sst_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  output logic fall
);
  logic [SYNC:0] chain_q;
  logic [SYNC:0] chain_d;

  always_comb chain_d = {chain_q[SYNC-1:0], ext_clk};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  // older stage high, newer stage low: one-cycle falling-edge event
  assign fall = chain_q[SYNC] & ~chain_q[SYNC-1];
endmodule

// File: rtl/sst_div.sv
module sst_div #(
  parameter int MDIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int DCW = (MDIV > 1) ? $clog2(MDIV) : 1;
  localparam logic [DCW-1:0] LAST = DCW'(MDIV - 1);

  logic [DCW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sst_engine.sv
module sst_engine
  import sst_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          len_sel,
  input  logic          shift_en,
  output logic          txd,
  output logic          buf_empty_p,
  output logic          tx_done_p,
  output logic          gap_active,
  output logic          hb_full
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LEN_FULL  = CW'(DW);
  localparam logic [CW-1:0] LEN_SHORT = CW'(DW - 1);

  tx_state_e     st_q, st_d;
  logic [DW-1:0] hb_q, hb_d;
  logic          hbf_q, hbf_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] flen_q, flen_d;
  logic          txd_q, txd_d;
  logic          emp_q, emp_d;
  logic          done_q, done_d;
  logic          load;

  always_comb begin
    st_d   = st_q;
    hb_d   = hb_q;
    hbf_d  = hbf_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    flen_d = flen_q;
    txd_d  = txd_q;
    emp_d  = 1'b0;
    done_d = 1'b0;
    load   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (hbf_q) begin
          load = 1'b1;
          st_d = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (shift_en) begin
          txd_d = sh_q[0];
          sh_d  = {1'b0, sh_q[DW-1:1]};
          cnt_d = CW'(1);
          st_d  = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (shift_en) begin
          if (cnt_q == flen_q) begin
            txd_d = 1'b1;
            if (hbf_q) begin
              st_d = ST_GAP1;
            end else begin
              done_d = 1'b1;
              st_d   = ST_IDLE;
            end
          end else begin
            txd_d = sh_q[0];
            sh_d  = {1'b0, sh_q[DW-1:1]};
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_GAP1: st_d = ST_GAP2;
      ST_GAP2: begin
        load = 1'b1;
        st_d = ST_ARMED;
      end
      default: st_d = ST_IDLE;
    endcase
    if (load) begin
      sh_d   = hb_q;
      hbf_d  = 1'b0;
      emp_d  = 1'b1;
      flen_d = len_sel ? LEN_SHORT : LEN_FULL;
    end
    if (wr_en) begin
      hb_d  = wr_data;
      hbf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hb_q   <= '0;
      hbf_q  <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
      flen_q <= LEN_FULL;
      txd_q  <= 1'b1;
      emp_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hb_q   <= hb_d;
      hbf_q  <= hbf_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      flen_q <= flen_d;
      txd_q  <= txd_d;
      emp_q  <= emp_d;
      done_q <= done_d;
    end
  end

  assign txd         = txd_q;
  assign buf_empty_p = emp_q;
  assign tx_done_p   = done_q;
  assign gap_active  = (st_q == ST_GAP1) || (st_q == ST_GAP2);
  assign hb_full     = hbf_q;
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx #(
  parameter int DW   = 8,
  parameter int MDIV = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          len_sel,
  input  logic          slave_sel,
  input  logic          ext_clk,
  output logic          txd,
  output logic          buf_empty_p,
  output logic          tx_done_p
);
  logic ext_fall;
  logic div_tick;
  logic shift_en;
  logic gap_active;
  logic hb_full;

  sst_edge #(.SYNC(SYNC)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_clk (ext_clk),
    .fall    (ext_fall)
  );

  sst_div #(.MDIV(MDIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (~slave_sel),
    .tick  (div_tick)
  );

  assign shift_en = slave_sel ? ext_fall : div_tick;

  sst_engine #(.DW(DW)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .len_sel     (len_sel),
    .shift_en    (shift_en),
    .txd         (txd),
    .buf_empty_p (buf_empty_p),
    .tx_done_p   (tx_done_p),
    .gap_active  (gap_active),
    .hb_full     (hb_full)
  );
endmodule

// File: rtl/sst_chk.sv
module sst_chk (
  input logic clk,
  input logic rst_n,
  input logic slave_sel,
  input logic shift_en,
  input logic wr_en,
  input logic hb_full,
  input logic gap_active,
  input logic txd,
  input logic buf_empty_p,
  input logic tx_done_p
);
  // R1: a slave-mode edge event lasts one cycle only
  a_r1_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_sel && shift_en) |=> !shift_en);

  // R1: line moves only right after a shift event
  a_r1_txd_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(shift_en));

  // R2: a write always leaves the buffer occupied
  a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> hb_full);

  // R2: empty pulse is one cycle wide
  a_r2_empty_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty_p |=> !buf_empty_p);

  // R5: completion pulse is one cycle wide
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_p |=> !tx_done_p);

  // R6: line held high during the reload gap
  a_r6_gap_high: assert property (@(posedge clk) disable iff (!rst_n)
    gap_active |-> txd);

  // R6: no completion in the same cycle as a reload
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_done_p && buf_empty_p));
endmodule

bind sync_ser_tx sst_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .slave_sel   (slave_sel),
  .shift_en    (shift_en),
  .wr_en       (wr_en),
  .hb_full     (hb_full),
  .gap_active  (gap_active),
  .txd         (txd),
  .buf_empty_p (buf_empty_p),
  .tx_done_p   (tx_done_p)
);

// File: tb/sync_ser_tx_test.sv
`timescale 1ns/1ps
module sync_ser_tx_test;
  localparam int DW   = 8;
  localparam int MDIV = 8;
  localparam int H    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          len_sel = 1'b0;
  logic          slave_sel = 1'b1;
  logic          ext_clk = 1'b1;
  logic          txd, buf_empty_p, tx_done_p;

  int n_chk = 0;
  int n_bad = 0;
  int done_cnt = 0;
  int empty_cnt = 0;
  int exp_done = 0;
  int exp_empty = 0;

  always #10 clk = ~clk;

  sync_ser_tx #(.DW(DW), .MDIV(MDIV), .SYNC(2)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .len_sel(len_sel), .slave_sel(slave_sel), .ext_clk(ext_clk),
    .txd(txd), .buf_empty_p(buf_empty_p), .tx_done_p(tx_done_p)
  );

  always @(negedge clk) begin
    if (tx_done_p)   done_cnt++;
    if (buf_empty_p) empty_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int frame_bits(input logic ls);
    return ls ? DW - 1 : DW;
  endfunction

  function automatic int bit_of(input logic [DW-1:0] w, input int i);
    return int'(w[i]);
  endfunction

  task automatic write_word(input logic [DW-1:0] w, input logic ls);
    @(negedge clk);
    len_sel = ls;
    wr_en   = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one external clock period; returns txd seen at the rising edge
  task automatic ext_cycle(output logic seen);
    @(negedge clk);
    ext_clk = 1'b0;
    repeat (H) @(negedge clk);
    ext_clk = 1'b1;
    seen = txd;
    repeat (H) @(negedge clk);
  endtask

  // send n bits of w; optionally queue a word after bit 3
  task automatic run_frame(input logic [DW-1:0] w, input int n, input string req,
                           input bit q_en, input logic [DW-1:0] qw, input logic ql);
    logic s;
    for (int i = 0; i < n; i++) begin
      ext_cycle(s);
      chk(req, int'(s), bit_of(w, i));
      if (q_en && i == 3) write_word(qw, ql);
    end
    ext_cycle(s);
    chk("R5 line high after last bit", int'(s), 1);
  endtask

  initial begin
    #(20ns * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic s;
    logic [DW-1:0] cur, nxt;
    logic cl, nl;
    bit cont;
    int t;
    void'($urandom(32'h5A17));

    repeat (3) @(negedge clk);
    chk("R7 reset txd", int'(txd), 1);
    chk("R7 reset empty pulse", int'(buf_empty_p), 0);
    chk("R7 reset done pulse", int'(tx_done_p), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 idle txd", int'(txd), 1);

    // R2/R3: single 8-bit frame
    write_word(8'hA5, 1'b0);
    repeat (4) @(negedge clk);
    exp_empty++;
    chk("R2 load pulse", empty_cnt, exp_empty);
    chk("R1 txd unchanged before first edge", int'(txd), 1);
    run_frame(8'hA5, 8, "R3 lsb-first bit", 1'b0, '0, 1'b0);
    repeat (6) @(negedge clk);
    exp_done++;
    chk("R5 done pulse", done_cnt, exp_done);

    // R4: 7-bit frame, bit7=0 must not appear
    write_word(8'h2A, 1'b1);
    repeat (4) @(negedge clk);
    exp_empty++;
    run_frame(8'h2A, 7, "R4 7-bit frame bit", 1'b0, '0, 1'b0);
    repeat (6) @(negedge clk);
    exp_done++;
    chk("R4 done after 7 bits", done_cnt, exp_done);

    // R6/R8: continuous, with double write during the frame
    write_word(8'h3C, 1'b0);
    repeat (4) @(negedge clk);
    exp_empty++;
    for (int i = 0; i < 8; i++) begin
      ext_cycle(s);
      chk("R3 first continuous frame bit", int'(s), bit_of(8'h3C, i));
      if (i == 2) write_word(8'h11, 1'b0);
      if (i == 4) write_word(8'hC6, 1'b0);
    end
    ext_cycle(s);
    chk("R6 gap line high", int'(s), 1);
    chk("R6 no done between frames", done_cnt, exp_done);
    exp_empty++;
    chk("R6 reload pulse", empty_cnt, exp_empty);
    run_frame(8'hC6, 8, "R8 overwritten word bit", 1'b0, '0, 1'b0);
    repeat (6) @(negedge clk);
    exp_done++;
    chk("R6 done after last queued frame", done_cnt, exp_done);

    // R9: stall external clock, queue a word, recover in master mode
    write_word(8'h96, 1'b0);
    repeat (4) @(negedge clk);
    exp_empty++;
    for (int i = 0; i < 3; i++) begin
      ext_cycle(s);
      chk("R9 pre-stall bit", int'(s), bit_of(8'h96, i));
    end
    write_word(8'h5B, 1'b0);
    repeat (30) @(negedge clk);
    chk("R9 stalled no done", done_cnt, exp_done);
    @(negedge clk);
    slave_sel = 1'b0;
    t = 0;
    while (done_cnt == exp_done && t < 600) begin
      @(negedge clk);
      t++;
    end
    exp_done++;
    exp_empty++;
    chk("R9 drained with one done", done_cnt, exp_done);
    chk("R9 queued word loaded", empty_cnt, exp_empty);
    chk("R9 master shift timing bound", int'(t > 10 * MDIV && t < 30 * MDIV), 1);
    chk("R9 line high after drain", int'(txd), 1);
    @(negedge clk);
    slave_sel = 1'b1;
    repeat (4) @(negedge clk);
    write_word(8'hE1, 1'b0);
    repeat (4) @(negedge clk);
    exp_empty++;
    run_frame(8'hE1, 8, "R9 resumed slave bit", 1'b0, '0, 1'b0);
    repeat (6) @(negedge clk);
    exp_done++;
    chk("R9 resumed done", done_cnt, exp_done);

    // random frames, random length, random queuing
    cur = DW'($urandom);
    cl  = 1'($urandom);
    write_word(cur, cl);
    repeat (4) @(negedge clk);
    exp_empty++;
    for (int k = 0; k < 24; k++) begin
      cont = (k < 23) && ($urandom % 2 == 1);
      nxt  = DW'($urandom);
      nl   = 1'($urandom);
      run_frame(cur, frame_bits(cl), "R3 random frame bit", cont, nxt, nl);
      repeat (6) @(negedge clk);
      if (!cont) exp_done++;
      chk("R6 random done count", done_cnt, exp_done);
      if (k < 23) begin
        if (!cont) begin
          write_word(nxt, nl);
          repeat (4) @(negedge clk);
        end
        exp_empty++;
        cur = nxt;
        cl  = nl;
      end
    end
    chk("R2 total load pulses", empty_cnt, exp_empty);
    chk("R7 final idle txd", int'(txd), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule